// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits between a bank of timer channels and the interrupt lines of the system. Each channel raises a one-cycle fire event. The channel's own settings decide how that event reaches software. A level-type channel sets a status bit and holds its line high until software clears it. An edge-type channel drives a single one-cycle pulse. A channel with message delivery enabled raises no line and produces a message-write request instead. Several channels may share one line, and the line is then the OR of their requests.

A global legacy bit makes channels 0 and 1 take over the system-timer line (`LINE_TMR`, default 0) and the RTC line (`LINE_RTC`, default 8). The external timer and RTC interrupt levels are shut off those lines while the bit is set. A four-state machine tracks the mode: `LG_NORMAL`, `LG_ENTER`, `LG_LEGACY` and `LG_EXIT`. Setting the bit moves `LG_NORMAL` to `LG_ENTER` and `LG_EXIT` to `LG_ENTER`. `LG_ENTER` moves to `LG_LEGACY` while the bit stays set, and to `LG_EXIT` if it drops. Clearing the bit moves `LG_LEGACY` (and `LG_ENTER`) to `LG_EXIT`, and `LG_EXIT` moves to `LG_NORMAL` while the bit stays clear. `LG_ENTER` forces both shared lines low for one cycle. `LG_EXIT` forces the timer line low for one cycle and puts the RTC line back to the RTC level that was recorded. The system-timer enable output is high in `LG_NORMAL` and `LG_EXIT`. The RTC input level is registered every cycle, whatever the mode.

Message requests are held per channel. They are issued one per cycle, lowest channel number first, as a one-cycle `msg_valid_o` pulse with address and data. The bus side of the write is outside this block.

Top module: `tir_router`

## Requirements
- R1: After reset, all interrupt lines are low, all status bits are 0, `msg_valid_o` is 0, `tmr_en_o` is 1 and the recorded RTC level is 0.
- R2: A fire on an active (channel enable and global enable both 1), level-type (`ch_level_i`=1), non-message channel sets its status bit on the next clock edge. The line named by its 5-bit route field (`ch_route_i[c*5 +: 5]`) is then held high until the status clears.
- R3: A fire on an active edge-type (`ch_level_i`=0), non-message channel drives its routed line high for exactly one cycle after the next edge and leaves its status bit unchanged.
- R4: A status bit clears on the next edge when its `clr_i` bit is 1, when its channel enable is 0, or when the global enable is 0. A fire on an inactive channel is ignored. A fire and a clear in the same cycle leave the bit set.
- R5: When several channels route to one line, the line is high while any of them requests it.
- R6: In `LG_NORMAL`, `ext_tmr_i` drives line `LINE_TMR` directly. The RTC level, registered one cycle, drives line `LINE_RTC`. Both are ORed with channel requests.
- R7: In `LG_LEGACY`, channel 0 drives `LINE_TMR` and channel 1 drives `LINE_RTC` regardless of their route fields. The external levels do not reach those lines, and `tmr_en_o` is 0. In general, `tmr_en_o` is 0 in the cycle after `legacy_i` is sampled 1.
- R8: In `LG_ENTER` (the cycle after `legacy_i` is first sampled 1), lines `LINE_TMR` and `LINE_RTC` are both low and `tmr_en_o` is 0.
- R9: In `LG_EXIT` (the cycle after `legacy_i` is first sampled 0 in legacy), `LINE_TMR` is low, `LINE_RTC` equals the recorded RTC level and `tmr_en_o` is 1. `tmr_en_o` is 1 in the cycle after any cycle with `legacy_i` 0.
- R10: A fire on an active channel with `ch_msg_en_i`=1 raises no line. Two edges later `msg_valid_o` is 1 for one cycle, with `msg_addr_o` equal to bits 63:32 and `msg_data_o` equal to bits 31:0 of that channel's 64-bit message route word.
- R11: Message requests pending together are issued on consecutive cycles in ascending channel order.
- R12: A 0-to-1 change of a channel's `ch_msg_en_i` clears that channel's status bit on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gbl_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy replacement request |
| ch_en_i | input | NCH | Per-channel enable |
| ch_level_i | input | NCH | 1 = level type, 0 = edge type |
| ch_msg_en_i | input | NCH | Per-channel message delivery enable |
| ch_route_i | input | NCH*RW | Per-channel line number, RW bits each |
| ch_msg_route_i | input | NCH*64 | Per-channel message word: address high, data low |
| fire_i | input | NCH | Per-channel fire event |
| clr_i | input | NCH | Per-channel status clear strobe |
| ext_tmr_i | input | 1 | External system-timer interrupt level |
| ext_rtc_i | input | 1 | External RTC interrupt level |
| irq_o | output | NLINES | Interrupt lines |
| tmr_en_o | output | 1 | Enable for the external system timer |
| status_o | output | NCH | Level-type status bits |
| msg_valid_o | output | 1 | Message-write request, one cycle |
| msg_addr_o | output | 32 | Message-write address |
| msg_data_o | output | 32 | Message-write data |

## Verification
The hardest state to reach from the ports is `LG_EXIT` holding an RTC level that changed while the external source was shut off. It lasts a single cycle and follows two mode changes. The stimulus keeps `ext_rtc_i` low before legacy entry and raises it only inside `LG_LEGACY`, where it must stay invisible. It then drops `legacy_i` and samples the exact `LG_EXIT` cycle, where line 8 must be high while line 0 is held low despite `ext_tmr_i` being high. Message ordering is checked by a scoreboard queue filled when two message channels fire in the same cycle.

// File: rtl/tir_pkg.sv
package tir_pkg;

    typedef enum logic [1:0] {
        LG_NORMAL = 2'd0,
        LG_ENTER  = 2'd1,
        LG_LEGACY = 2'd2,
        LG_EXIT   = 2'd3
    } leg_state_e;

endpackage

// File: rtl/tir_chan.sv
module tir_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic level_i,
    input  logic msg_en_i,
    input  logic fire_i,
    input  logic clr_i,
    output logic status_o,
    output logic req_o,
    output logic msg_set_o
);

    logic status_q;
    logic pulse_q;
    logic msg_en_q;
    logic msg_rise;
    logic fire_lvl;
    logic fire_edge;

    assign msg_rise  = msg_en_i & ~msg_en_q;
    assign fire_lvl  = active_i & fire_i & level_i & ~msg_en_i;
    assign fire_edge = active_i & fire_i & ~level_i & ~msg_en_i;
    assign msg_set_o = active_i & fire_i & msg_en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            pulse_q  <= 1'b0;
            msg_en_q <= 1'b0;
        end else begin
            msg_en_q <= msg_en_i;
            pulse_q  <= fire_edge;
            if (!active_i) begin
                status_q <= 1'b0;
            end else if (fire_lvl) begin
                status_q <= 1'b1;
            end else if (clr_i || msg_rise) begin
                status_q <= 1'b0;
            end
        end
    end

    assign status_o = status_q;
    assign req_o    = status_q | pulse_q;

endmodule

// File: rtl/tir_legacy_fsm.sv
module tir_legacy_fsm
    import tir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       legacy_i,
    output leg_state_e state_o,
    output logic       tmr_en_o
);

    leg_state_e state_q;
    leg_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LG_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LG_NORMAL: if (legacy_i)  state_d = LG_ENTER;
            LG_ENTER:  state_d = legacy_i ? LG_LEGACY : LG_EXIT;
            LG_LEGACY: if (!legacy_i) state_d = LG_EXIT;
            LG_EXIT:   state_d = legacy_i ? LG_ENTER : LG_NORMAL;
        endcase
    end

    always_comb begin
        tmr_en_o = 1'b1;
        unique case (state_q)
            LG_NORMAL: tmr_en_o = 1'b1;
            LG_ENTER:  tmr_en_o = 1'b0;
            LG_LEGACY: tmr_en_o = 1'b0;
            LG_EXIT:   tmr_en_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/tir_msg_arb.sv
module tir_msg_arb #(
    parameter  int NCH    = 4,
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int MW     = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    set_i,
    input  logic [NCH-1:0]    active_i,
    input  logic [NCH*MW-1:0] route_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    logic [NCH-1:0]    pend_q;
    logic [NCH-1:0]    elig;
    logic [NCH-1:0]    grant;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;

    assign elig  = pend_q & active_i;
    assign grant = elig & (~elig + NCH'(1));

    always_comb begin
        sel_addr = '0;
        sel_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (grant[c]) begin
                sel_addr = route_i[c*MW+DATA_W +: ADDR_W];
                sel_data = route_i[c*MW +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            valid_o <= 1'b0;
            addr_o  <= '0;
            data_o  <= '0;
        end else begin
            pend_q  <= (elig & ~grant) | set_i;
            valid_o <= |grant;
            if (|grant) begin
                addr_o <= sel_addr;
                data_o <= sel_data;
            end
        end
    end

endmodule

// File: rtl/tir_router.sv
module tir_router
    import tir_pkg::*;
#(
    parameter  int NCH      = 4,
    parameter  int NLINES   = 24,
    parameter  int LINE_TMR = 0,
    parameter  int LINE_RTC = 8,
    parameter  int ADDR_W   = 32,
    parameter  int DATA_W   = 32,
    localparam int RW       = $clog2(NLINES),
    localparam int MW       = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gbl_en_i,
    input  logic              legacy_i,
    input  logic [NCH-1:0]    ch_en_i,
    input  logic [NCH-1:0]    ch_level_i,
    input  logic [NCH-1:0]    ch_msg_en_i,
    input  logic [NCH*RW-1:0] ch_route_i,
    input  logic [NCH*MW-1:0] ch_msg_route_i,
    input  logic [NCH-1:0]    fire_i,
    input  logic [NCH-1:0]    clr_i,
    input  logic              ext_tmr_i,
    input  logic              ext_rtc_i,
    output logic [NLINES-1:0] irq_o,
    output logic              tmr_en_o,
    output logic [NCH-1:0]    status_o,
    output logic              msg_valid_o,
    output logic [ADDR_W-1:0] msg_addr_o,
    output logic [DATA_W-1:0] msg_data_o
);

    leg_state_e        lg_state;
    logic              map_on;
    logic              rtc_q;
    logic [NCH-1:0]    ch_active;
    logic [NCH-1:0]    ch_req;
    logic [NCH-1:0]    ch_msg_set;
    logic [RW-1:0]     eff_route [NCH];
    logic [NLINES-1:0] line_req;

    assign ch_active = ch_en_i & {NCH{gbl_en_i}};
    assign map_on    = (lg_state == LG_ENTER) || (lg_state == LG_LEGACY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtc_q <= 1'b0;
        end else begin
            rtc_q <= ext_rtc_i;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tir_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (ch_active[c]),
            .level_i  (ch_level_i[c]),
            .msg_en_i (ch_msg_en_i[c]),
            .fire_i   (fire_i[c]),
            .clr_i    (clr_i[c]),
            .status_o (status_o[c]),
            .req_o    (ch_req[c]),
            .msg_set_o(ch_msg_set[c])
        );
    end

    tir_legacy_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .legacy_i(legacy_i),
        .state_o (lg_state),
        .tmr_en_o(tmr_en_o)
    );

    tir_msg_arb #(
        .NCH   (NCH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ch_msg_set),
        .active_i(ch_active),
        .route_i (ch_msg_route_i),
        .valid_o (msg_valid_o),
        .addr_o  (msg_addr_o),
        .data_o  (msg_data_o)
    );

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            eff_route[c] = ch_route_i[c*RW +: RW];
            if (map_on && c == 0) eff_route[c] = RW'(LINE_TMR);
            if (map_on && c == 1) eff_route[c] = RW'(LINE_RTC);
        end
    end

    always_comb begin
        line_req = '0;
        for (int l = 0; l < NLINES; l++) begin
            for (int c = 0; c < NCH; c++) begin
                if (ch_req[c] && eff_route[c] == RW'(l)) line_req[l] = 1'b1;
            end
        end
    end

    always_comb begin
        irq_o = line_req;
        unique case (lg_state)
            LG_NORMAL: begin
                irq_o[LINE_TMR] = line_req[LINE_TMR] | ext_tmr_i;
                irq_o[LINE_RTC] = line_req[LINE_RTC] | rtc_q;
            end
            LG_ENTER: begin
                irq_o[LINE_TMR] = 1'b0;
                irq_o[LINE_RTC] = 1'b0;
            end
            LG_LEGACY: begin
                irq_o = line_req;
            end
            LG_EXIT: begin
                irq_o[LINE_TMR] = 1'b0;
                irq_o[LINE_RTC] = rtc_q;
            end
        endcase
    end

endmodule

// File: rtl/tir_router_chk.sv
module tir_router_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           gbl_en_i,
    input logic           legacy_i,
    input logic [NCH-1:0] ch_en_i,
    input logic [NCH-1:0] ch_level_i,
    input logic [NCH-1:0] ch_msg_en_i,
    input logic [NCH-1:0] fire_i,
    input logic [NCH-1:0] clr_i,
    input logic [NCH-1:0] status_o,
    input logic           tmr_en_o
);

    // R7
    legacy_tmr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> !tmr_en_o);

    // R9
    normal_tmr_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_i |=> tmr_en_o);

    // R4
    gbl_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gbl_en_i |=> (status_o == '0));

    // R4
    clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_o & $past(clr_i & ~fire_i)) == '0));

    // R2
    status_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_o & ~$past(status_o)
                    & ~$past(fire_i & ch_level_i & ~ch_msg_en_i & ch_en_i
                             & {NCH{gbl_en_i}})) == '0));

endmodule

bind tir_router tir_router_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gbl_en_i   (gbl_en_i),
    .legacy_i   (legacy_i),
    .ch_en_i    (ch_en_i),
    .ch_level_i (ch_level_i),
    .ch_msg_en_i(ch_msg_en_i),
    .fire_i     (fire_i),
    .clr_i      (clr_i),
    .status_o   (status_o),
    .tmr_en_o   (tmr_en_o)
);

// File: tb/tir_router_tb.sv
`timescale 1ns/1ps
module tir_router_tb;

    localparam int NCH = 4;
    localparam int NLINES = 24;
    localparam int RW = 5;
    localparam int MW = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              gbl_en = 1'b0;
    logic              legacy = 1'b0;
    logic [NCH-1:0]    ch_en = '0;
    logic [NCH-1:0]    ch_level = '0;
    logic [NCH-1:0]    ch_msg_en = '0;
    logic [NCH*RW-1:0] ch_route = '0;
    logic [NCH*MW-1:0] ch_msg_route = '0;
    logic [NCH-1:0]    fire = '0;
    logic [NCH-1:0]    clr = '0;
    logic              ext_tmr = 1'b0;
    logic              ext_rtc = 1'b0;
    logic [NLINES-1:0] irq;
    logic              tmr_en;
    logic [NCH-1:0]    status;
    logic              msg_valid;
    logic [31:0]       msg_addr;
    logic [31:0]       msg_data;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] exp_q[$];

    always #2 clk = ~clk;

    tir_router #(.NCH(NCH), .NLINES(NLINES)) u_dut (
        .clk(clk), .rst_n(rst_n), .gbl_en_i(gbl_en), .legacy_i(legacy),
        .ch_en_i(ch_en), .ch_level_i(ch_level), .ch_msg_en_i(ch_msg_en),
        .ch_route_i(ch_route), .ch_msg_route_i(ch_msg_route),
        .fire_i(fire), .clr_i(clr), .ext_tmr_i(ext_tmr), .ext_rtc_i(ext_rtc),
        .irq_o(irq), .tmr_en_o(tmr_en), .status_o(status),
        .msg_valid_o(msg_valid), .msg_addr_o(msg_addr), .msg_data_o(msg_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // scoreboard monitor for message writes
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected message", {msg_addr, msg_data}, 64'hx);
            end else begin
                chk("R10/R11 message", {msg_addr, msg_data}, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 tmr_en", 64'(tmr_en), 64'd1);
        chk("R1 status", 64'(status), 64'd0);
        chk("R1 msg_valid", 64'(msg_valid), 64'd0);
        rst_n = 1'b1;
        gbl_en = 1'b1;
        ch_en = 4'b1111;
        ch_level = 4'b0011;
        ch_route[0*RW +: RW] = 5'd3;
        ch_route[1*RW +: RW] = 5'd5;
        ch_route[2*RW +: RW] = 5'd3;
        ch_route[3*RW +: RW] = 5'd10;
        ch_msg_route[2*MW +: MW] = {32'hFEE0_1000, 32'h0000_0042};
        ch_msg_route[3*MW +: MW] = {32'hFEE0_2000, 32'h0000_0043};
        step();
        chk("R1 recorded rtc low", 64'(irq[8]), 64'd0);

        // R2 level channel
        fire = 4'b0010; step(); fire = '0;
        chk("R2 status", 64'(status), 64'b0010);
        chk("R2 line5", 64'(irq[5]), 64'd1);
        step();
        chk("R2 line5 held", 64'(irq[5]), 64'd1);
        clr = 4'b0010; step(); clr = '0;
        chk("R4 clr status", 64'(status), 64'd0);
        chk("R4 clr line5", 64'(irq[5]), 64'd0);

        // R3 edge channel
        fire = 4'b1000; step(); fire = '0;
        chk("R3 pulse high", 64'(irq[10]), 64'd1);
        chk("R3 status unchanged", 64'(status), 64'd0);
        step();
        chk("R3 pulse one cycle", 64'(irq[10]), 64'd0);

        // R5 sharing line 3
        fire = 4'b0001; step(); fire = '0;
        chk("R5 line3 from ch0", 64'(irq[3]), 64'd1);
        clr = 4'b0001; fire = 4'b0100; step(); clr = '0; fire = '0;
        chk("R5 line3 from ch2 pulse", 64'(irq[3]), 64'd1);
        chk("R5 ch0 cleared", 64'(status), 64'd0);
        step();
        chk("R5 line3 low", 64'(irq[3]), 64'd0);

        // R4 fire and clear together, disable, global off
        fire = 4'b0001; step(); fire = '0;
        clr = 4'b0001; fire = 4'b0001; step(); clr = '0; fire = '0;
        chk("R4 set wins over clr", 64'(status), 64'b0001);
        ch_en[0] = 1'b0; step();
        chk("R4 disable clears", 64'(status), 64'd0);
        chk("R4 disable line3", 64'(irq[3]), 64'd0);
        fire = 4'b0001; step(); fire = '0;
        chk("R4 fire ignored when disabled", 64'(status), 64'd0);
        ch_en[0] = 1'b1; step();
        chk("R4 re-enable stays clear", 64'(status), 64'd0);
        fire = 4'b0010; step(); fire = '0;
        gbl_en = 1'b0; step();
        chk("R4 global off clears", 64'(status), 64'd0);
        chk("R4 global off line5", 64'(irq[5]), 64'd0);
        gbl_en = 1'b1;

        // R6 passthrough
        ext_tmr = 1'b1; step();
        chk("R6 tmr passthrough", 64'(irq[0]), 64'd1);
        ext_rtc = 1'b1; step();
        chk("R6 rtc passthrough", 64'(irq[8]), 64'd1);
        ext_rtc = 1'b0; step();
        chk("R6 rtc low", 64'(irq[8]), 64'd0);

        // R8 entry
        legacy = 1'b1; step();
        chk("R8 tmr_en low", 64'(tmr_en), 64'd0);
        chk("R8 line0 low", 64'(irq[0]), 64'd0);
        chk("R8 line8 low", 64'(irq[8]), 64'd0);
        // R7 legacy mapping
        fire = 4'b0011; ext_rtc = 1'b1; step(); fire = '0;
        chk("R7 ch0 to line0", 64'(irq[0]), 64'd1);
        chk("R7 ch1 to line8", 64'(irq[8]), 64'd1);
        chk("R7 route3 unused", 64'(irq[3]), 64'd0);
        chk("R7 route5 unused", 64'(irq[5]), 64'd0);
        clr = 4'b0011; step(); clr = '0;
        chk("R7 ext tmr suppressed", 64'(irq[0]), 64'd0);
        chk("R7 ext rtc suppressed", 64'(irq[8]), 64'd0);
        chk("R7 tmr_en low", 64'(tmr_en), 64'd0);

        // R9 exit
        legacy = 1'b0; step();
        chk("R9 tmr_en high", 64'(tmr_en), 64'd1);
        chk("R9 line0 low", 64'(irq[0]), 64'd0);
        chk("R9 line8 restored", 64'(irq[8]), 64'd1);
        step();
        chk("R9 back to normal line0", 64'(irq[0]), 64'd1);
        ext_tmr = 1'b0; ext_rtc = 1'b0; step();

        // R10 message delivery
        ch_msg_en = 4'b0100; step();
        fire = 4'b0100; exp_q.push_back({32'hFEE0_1000, 32'h0000_0042});
        step(); fire = '0;
        chk("R10 no line", 64'(irq[3]), 64'd0);
        repeat (3) step();

        // R11 ordering
        ch_msg_en = 4'b1100; step();
        fire = 4'b1100;
        exp_q.push_back({32'hFEE0_1000, 32'h0000_0042});
        exp_q.push_back({32'hFEE0_2000, 32'h0000_0043});
        step(); fire = '0;
        repeat (4) step();
        chk("R11 queue drained", 64'(exp_q.size()), 64'd0);

        // R12 message enable clears pending status
        fire = 4'b0001; step(); fire = '0;
        chk("R12 status set", 64'(status), 64'b0001);
        ch_msg_en[0] = 1'b1; step();
        chk("R12 status cleared", 64'(status), 64'd0);
        chk("R12 line3 low", 64'(irq[3]), 64'd0);
        repeat (3) step();
        chk("R10 no stray message", 64'(exp_q.size()), 64'd0);
        summary();
    end

endmodule